// File: doc/BRIEF.md
# Banked Translation-Base Register Access Controller

This block holds a 64-bit translation-table base register in two physical copies, one for the secure world and one for the non-secure world, and places in front of it the logic that decides whether a coprocessor-style access may proceed. Each request carries a coprocessor encoding, a flag choosing a 32-bit single transfer or a 64-bit paired transfer, a read/write flag and write data. The block compares the request against the current exception level, the hypervisor enable and its trap controls, the secure-state bit and two hardware disable pins. It then completes the access, raises an undefined-instruction flag, or reports a hypervisor trap with a syndrome code.

The kernel and hypervisor levels always use the non-secure copy. When the secure monitor level runs in 32-bit state, that copy is the non-secure bank. Otherwise it is the only copy. At the monitor level the secure-state bit picks the bank. An accepted request is answered one cycle later by a single-cycle response.

Top module: `xbase_ctrl`

## Requirements
- R1: A single transfer (`req_pair`=0) is claimed only for coprocessor 15, opc1 0, CRn 2, CRm 0, opc2 1. A paired transfer (`req_pair`=1) is claimed only for coprocessor 15, opc1 1, CRm 2; its CRn and opc2 fields are ignored. An unclaimed request gives no response and changes no copy.
- R2: A claimed request at level 0 (`cur_el`=0) sets `rsp_undef` and changes no copy.
- R3: At level 1 with `hyp_en`=1, `hyp_trap_grp`=1 traps both reads and writes, whatever the other two trap bits are.
- R4: At level 1 with `hyp_en`=1, `hyp_trap_rd`=1 traps reads only and `hyp_trap_wr`=1 traps writes only. With `hyp_en`=0 no level-1 access traps. Level 2 never traps.
- R5: `rsp_syndrome` is 0x03 on a trapped single transfer, 0x04 on a trapped paired transfer, and 0 when no trap is reported.
- R6: Accesses at levels 1 and 2 read and write the non-secure copy.
- R7: At level 3 (`cur_el`=3), `sec_ns`=0 selects the secure copy and `sec_ns`=1 selects the non-secure copy.
- R8: At level 3 with `sec_ns`=0, a single write is undefined when `sdis_a` or `sdis_b` is high. A paired write is undefined only when `sdis_a` is high. Reads are never blocked by these pins.
- R9: A single write stores `req_wdata_lo` in bits [31:0] and zero in bits [63:32]. A single read returns bits [31:0] on `rsp_rdata_lo` with `rsp_rdata_hi`=0.
- R10: A paired write stores `req_wdata_hi` in bits [63:32] and `req_wdata_lo` in bits [31:0]. A paired read returns the same split.
- R11: A claimed request is answered in the next cycle by a one-cycle `rsp_valid`. `rsp_undef` and `rsp_trap` are never both high. A trapped or undefined request modifies no copy, and read data is zero unless a read completed.
- R12: After reset both copies read zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_cp | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_opc2 | input | 3 | Second opcode field |
| req_pair | input | 1 | 1 = 64-bit paired transfer, 0 = 32-bit single |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata_lo | input | 32 | Write data, first transfer register |
| req_wdata_hi | input | 32 | Write data, second transfer register |
| cur_el | input | 2 | Current exception level 0..3 |
| hyp_en | input | 1 | Hypervisor enabled |
| hyp_trap_grp | input | 1 | Register-group trap, reads and writes |
| hyp_trap_rd | input | 1 | Read trap control |
| hyp_trap_wr | input | 1 | Write trap control |
| sec_ns | input | 1 | Secure-state bit at monitor level |
| sdis_a | input | 1 | First secure-write disable pin |
| sdis_b | input | 1 | Second secure-write disable pin |
| rsp_valid | output | 1 | Response for a claimed request |
| rsp_rdata_lo | output | 32 | Read data bits [31:0] |
| rsp_rdata_hi | output | 32 | Read data bits [63:32] |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_trap | output | 1 | Hypervisor trap outcome |
| rsp_syndrome | output | 8 | Trap syndrome code |

## Verification
A write request and a fault decision are resolved at the same clock edge. In the same cycle, the disable pins or a trap bit can veto the store update that the write data would cause. The bench provokes this by sweeping every combination of level, transfer size, direction, trap controls, secure bit and both disable pins with fresh data on each access. After each access it reads both copies back through the paired-read path, so a vetoed write that leaked into a bank shows up as a mismatch against the bench's model. The second coincidence is a read and a prior write to the same bank. Each readback follows the preceding access directly and must return exactly the data that the model expects.

// File: rtl/xbase_pkg.sv
package xbase_pkg;

  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_SINGLE = 2'd1,
    XFER_PAIR   = 2'd2
  } xfer_e;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } lvl_e;

  typedef struct packed {
    logic undef;
    logic trap;
    logic sel_secure;
  } verdict_t;

  localparam logic [7:0] SYN_SINGLE = 8'h03;
  localparam logic [7:0] SYN_PAIR   = 8'h04;

  // Build the stored image of a write: single transfers clear the upper half.
  function automatic logic [63:0] write_image(input logic pair,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
    return pair ? {hi, lo} : {32'd0, lo};
  endfunction

  // Shape the returned data of a read from the stored image.
  function automatic logic [63:0] read_image(input logic pair,
                                             input logic [63:0] stored);
    return pair ? stored : {32'd0, stored[31:0]};
  endfunction

endpackage

// File: rtl/xbase_decode.sv
module xbase_decode
  import xbase_pkg::*;
#(
  parameter int unsigned CP_NUM   = 15,
  parameter int unsigned S_OPC1   = 0,
  parameter int unsigned S_CRN    = 2,
  parameter int unsigned S_CRM    = 0,
  parameter int unsigned S_OPC2   = 1,
  parameter int unsigned P_OPC1   = 1,
  parameter int unsigned P_CRM    = 2
) (
  input  logic [3:0] cp,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  input  logic       pair,
  output xfer_e      xfer
);

  logic single_hit;
  logic pair_hit;

  assign single_hit = !pair && (cp == 4'(CP_NUM)) && (opc1 == 3'(S_OPC1)) &&
                      (crn == 4'(S_CRN)) && (crm == 4'(S_CRM)) &&
                      (opc2 == 3'(S_OPC2));
  // CRn and opc2 carry no meaning for paired transfers.
  assign pair_hit   = pair && (cp == 4'(CP_NUM)) && (opc1 == 3'(P_OPC1)) &&
                      (crm == 4'(P_CRM));

  always_comb begin
    if (single_hit)    xfer = XFER_SINGLE;
    else if (pair_hit) xfer = XFER_PAIR;
    else               xfer = XFER_NONE;
  end

endmodule

// File: rtl/xbase_policy.sv
module xbase_policy
  import xbase_pkg::*;
(
  input  xfer_e       xfer,
  input  logic [1:0]  cur_el,
  input  logic        write,
  input  logic        hyp_en,
  input  logic        trap_grp,
  input  logic        trap_rd,
  input  logic        trap_wr,
  input  logic        sec_ns,
  input  logic        sdis_a,
  input  logic        sdis_b,
  output verdict_t    verdict
);

  logic secure_blocked;
  logic kernel_trap;

  // Pin b only guards single transfers; pin a guards both sizes.
  assign secure_blocked = sdis_a || ((xfer == XFER_SINGLE) && sdis_b);
  // Group trap first, then the direction-specific control.
  assign kernel_trap    = hyp_en && (trap_grp || (write ? trap_wr : trap_rd));

  always_comb begin
    verdict = '0;
    unique case (lvl_e'(cur_el))
      LVL_USER:   verdict.undef = 1'b1;
      LVL_KERNEL: verdict.trap  = kernel_trap;
      LVL_HYP:    verdict       = '0;
      LVL_MON: begin
        verdict.sel_secure = !sec_ns;
        verdict.undef      = !sec_ns && write && secure_blocked;
      end
      default:    verdict       = '0;
    endcase
  end

endmodule

// File: rtl/xbase_store.sv
module xbase_store #(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [REG_W-1:0]                  wr_data,
  output logic [NUM_BANKS-1:0][REG_W-1:0]   bank_q
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bank_q[b] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(b)))      bank_q[b] <= wr_data;
    end
  end

endmodule

// File: rtl/xbase_ctrl.sv
module xbase_ctrl
  import xbase_pkg::*;
#(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned SYN_W     = 8,
  localparam int unsigned HALF_W   = REG_W / 2,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam logic [IDX_W-1:0] IDX_SEC = IDX_W'(0),
  localparam logic [IDX_W-1:0] IDX_NS  = IDX_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_cp,
  input  logic [2:0]        req_opc1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_opc2,
  input  logic              req_pair,
  input  logic              req_write,
  input  logic [31:0]       req_wdata_lo,
  input  logic [31:0]       req_wdata_hi,
  input  logic [1:0]        cur_el,
  input  logic              hyp_en,
  input  logic              hyp_trap_grp,
  input  logic              hyp_trap_rd,
  input  logic              hyp_trap_wr,
  input  logic              sec_ns,
  input  logic              sdis_a,
  input  logic              sdis_b,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata_lo,
  output logic [31:0]       rsp_rdata_hi,
  output logic              rsp_undef,
  output logic              rsp_trap,
  output logic [SYN_W-1:0]  rsp_syndrome
);

  xfer_e                            xfer;
  verdict_t                         verdict;
  logic                             accept;
  logic                             is_pair;
  logic                             fault;
  logic                             commit_wr;
  logic                             read_ok;
  logic [IDX_W-1:0]                 bank_idx;
  logic [REG_W-1:0]                 wr_image;
  logic [REG_W-1:0]                 rd_image;
  logic [NUM_BANKS-1:0][REG_W-1:0]  bank_q;

  xbase_decode u_decode (
    .cp   (req_cp),
    .opc1 (req_opc1),
    .crn  (req_crn),
    .crm  (req_crm),
    .opc2 (req_opc2),
    .pair (req_pair),
    .xfer (xfer)
  );

  xbase_policy u_policy (
    .xfer     (xfer),
    .cur_el   (cur_el),
    .write    (req_write),
    .hyp_en   (hyp_en),
    .trap_grp (hyp_trap_grp),
    .trap_rd  (hyp_trap_rd),
    .trap_wr  (hyp_trap_wr),
    .sec_ns   (sec_ns),
    .sdis_a   (sdis_a),
    .sdis_b   (sdis_b),
    .verdict  (verdict)
  );

  // Named events for the checker.
  assign accept    = req_valid && (xfer != XFER_NONE);
  assign is_pair   = (xfer == XFER_PAIR);
  assign fault     = verdict.undef || verdict.trap;
  assign commit_wr = accept && req_write && !fault;
  assign read_ok   = accept && !req_write && !fault;
  assign bank_idx  = verdict.sel_secure ? IDX_SEC : IDX_NS;

  assign wr_image  = REG_W'(write_image(is_pair, req_wdata_lo, req_wdata_hi));
  assign rd_image  = REG_W'(read_image(is_pair, 64'(bank_q[bank_idx])));

  xbase_store #(
    .REG_W     (REG_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit_wr),
    .wr_idx  (bank_idx),
    .wr_data (wr_image),
    .bank_q  (bank_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_undef    <= 1'b0;
      rsp_trap     <= 1'b0;
      rsp_syndrome <= '0;
      rsp_rdata_lo <= '0;
      rsp_rdata_hi <= '0;
    end else begin
      rsp_valid    <= accept;
      rsp_undef    <= accept && verdict.undef;
      rsp_trap     <= accept && verdict.trap;
      rsp_syndrome <= (accept && verdict.trap) ?
                      SYN_W'(is_pair ? SYN_PAIR : SYN_SINGLE) : '0;
      rsp_rdata_lo <= read_ok ? rd_image[HALF_W-1:0]     : '0;
      rsp_rdata_hi <= read_ok ? rd_image[REG_W-1:HALF_W] : '0;
    end
  end

endmodule

// File: rtl/xbase_ctrl_chk.sv
module xbase_ctrl_chk #(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned SYN_W     = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             accept,
  input logic                             is_pair,
  input logic                             req_write,
  input logic [1:0]                       cur_el,
  input logic                             hyp_en,
  input logic                             hyp_trap_grp,
  input logic                             sec_ns,
  input logic                             sdis_a,
  input logic                             rsp_valid,
  input logic                             rsp_undef,
  input logic                             rsp_trap,
  input logic [SYN_W-1:0]                 rsp_syndrome,
  input logic [NUM_BANKS-1:0][REG_W-1:0]  bank_q
);

  a_r11_exclusive_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_undef && rsp_trap));

  a_r11_reply_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> (!rsp_valid && !rsp_undef && !rsp_trap));

  a_r11_fault_keeps_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_undef || rsp_trap) |-> $stable(bank_q));

  a_r5_syndrome_by_size: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_syndrome == ($past(is_pair) ? SYN_W'(4) : SYN_W'(3))));

  a_r2_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_el == 2'd0) |=> rsp_undef);

  a_r3_group_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_el == 2'd1 && hyp_en && hyp_trap_grp) |=> rsp_trap);

  a_r8_pin_a_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_el == 2'd3 && !sec_ns && req_write && sdis_a) |=> rsp_undef);

endmodule

bind xbase_ctrl xbase_ctrl_chk #(
  .REG_W     (REG_W),
  .NUM_BANKS (NUM_BANKS),
  .SYN_W     (SYN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .is_pair      (is_pair),
  .req_write    (req_write),
  .cur_el       (cur_el),
  .hyp_en       (hyp_en),
  .hyp_trap_grp (hyp_trap_grp),
  .sec_ns       (sec_ns),
  .sdis_a       (sdis_a),
  .rsp_valid    (rsp_valid),
  .rsp_undef    (rsp_undef),
  .rsp_trap     (rsp_trap),
  .rsp_syndrome (rsp_syndrome),
  .bank_q       (bank_q)
);

// File: tb/xbase_ctrl_bench.sv
`timescale 1ns/1ps
module xbase_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cp = '0;
  logic [2:0]  req_opc1 = '0;
  logic [3:0]  req_crn = '0;
  logic [3:0]  req_crm = '0;
  logic [2:0]  req_opc2 = '0;
  logic        req_pair = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata_lo = '0;
  logic [31:0] req_wdata_hi = '0;
  logic [1:0]  cur_el = '0;
  logic        hyp_en = 1'b0;
  logic        hyp_trap_grp = 1'b0;
  logic        hyp_trap_rd = 1'b0;
  logic        hyp_trap_wr = 1'b0;
  logic        sec_ns = 1'b0;
  logic        sdis_a = 1'b0;
  logic        sdis_b = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata_lo;
  logic [31:0] rsp_rdata_hi;
  logic        rsp_undef;
  logic        rsp_trap;
  logic [7:0]  rsp_syndrome;

  always #5 clk = ~clk;

  xbase_ctrl u_xbase_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_cp(req_cp), .req_opc1(req_opc1), .req_crn(req_crn),
    .req_crm(req_crm), .req_opc2(req_opc2), .req_pair(req_pair),
    .req_write(req_write), .req_wdata_lo(req_wdata_lo),
    .req_wdata_hi(req_wdata_hi), .cur_el(cur_el), .hyp_en(hyp_en),
    .hyp_trap_grp(hyp_trap_grp), .hyp_trap_rd(hyp_trap_rd),
    .hyp_trap_wr(hyp_trap_wr), .sec_ns(sec_ns), .sdis_a(sdis_a),
    .sdis_b(sdis_b), .rsp_valid(rsp_valid), .rsp_rdata_lo(rsp_rdata_lo),
    .rsp_rdata_hi(rsp_rdata_hi), .rsp_undef(rsp_undef),
    .rsp_trap(rsp_trap), .rsp_syndrome(rsp_syndrome)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [63:0] m_sec = '0;
  logic [63:0] m_ns  = '0;

  logic        g_valid, g_undef, g_trap;
  logic [7:0]  g_syn;
  logic [63:0] g_data;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic claim(input logic pair);
    req_pair = pair;
    req_cp   = 4'd15;
    if (pair) begin
      req_opc1 = 3'd1; req_crm = 4'd2; req_crn = 4'd0; req_opc2 = 3'd0;
    end else begin
      req_opc1 = 3'd0; req_crn = 4'd2; req_crm = 4'd0; req_opc2 = 3'd1;
    end
  endtask

  task automatic quiet_ctrl();
    hyp_en = 0; hyp_trap_grp = 0; hyp_trap_rd = 0; hyp_trap_wr = 0;
    sdis_a = 0; sdis_b = 0;
  endtask

  task automatic fire();
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    g_valid = rsp_valid; g_undef = rsp_undef; g_trap = rsp_trap;
    g_syn   = rsp_syndrome; g_data = {rsp_rdata_hi, rsp_rdata_lo};
  endtask

  // Paired read of one copy: level 3 with ns=0 for secure, level 2 for non-secure.
  task automatic read_bank(input bit secure, output logic [63:0] val);
    quiet_ctrl();
    claim(1'b1);
    req_write = 1'b0;
    cur_el    = secure ? 2'd3 : 2'd2;
    sec_ns    = 1'b0;
    fire();
    val = g_data;
  endtask

  task automatic verify_banks(input string tag);
    logic [63:0] v;
    read_bank(1'b1, v);
    chk({tag, " secure copy"}, v, m_sec);
    read_bank(1'b0, v);
    chk({tag, " non-secure copy"}, v, m_ns);
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 no response after reset", {63'd0, rsp_valid}, 64'd0);
    verify_banks("R12 reset");

    // R1: encodings that must not be claimed
    for (int k = 0; k < 8; k++) begin
      quiet_ctrl();
      cur_el = 2'd2; req_write = 1'b1;
      req_wdata_lo = 32'hDEAD_0000 + k; req_wdata_hi = 32'hBEEF_0000 + k;
      claim(k >= 5);
      case (k)
        0: req_cp   = 4'd14;
        1: req_opc1 = 3'd1;
        2: req_crn  = 4'd3;
        3: req_crm  = 4'd1;
        4: req_opc2 = 3'd0;
        5: req_cp   = 4'd14;
        6: req_opc1 = 3'd0;
        default: req_crm = 4'd3;
      endcase
      fire();
      chk("R1 unclaimed encoding gives no response", {63'd0, g_valid}, 64'd0);
    end
    verify_banks("R1 unclaimed writes");

    // R1: paired transfer ignores CRn and opc2
    quiet_ctrl();
    claim(1'b1); req_crn = 4'd9; req_opc2 = 3'd5;
    cur_el = 2'd2; req_write = 1'b1;
    req_wdata_lo = 32'h1357_9BDF; req_wdata_hi = 32'h2468_ACE0;
    fire();
    m_ns = 64'h2468_ACE0_1357_9BDF;
    chk("R1 paired claim ignores CRn/opc2", {63'd0, g_valid}, 64'd1);
    read_bank(1'b0, v);
    chk("R10 paired write lands", v, m_ns);

    // R9: single write after paired write clears the upper half
    claim(1'b0); cur_el = 2'd2; req_write = 1'b1; req_wdata_lo = 32'h0000_00A5;
    fire();
    m_ns = 64'h0000_0000_0000_00A5;
    read_bank(1'b0, v);
    chk("R9 single write zero-extends", v, m_ns);

    // Sweep: level, size, direction, trap controls, secure bit, disable pins
    for (int code = 0; code < 2048; code++) begin
      logic [1:0]  el;
      logic        pr, wr, he, tg, tr, tw, ns, da, db;
      logic        e_undef, e_trap, e_sec;
      logic [63:0] e_data, cur, img;
      el = code[1:0]; pr = code[2]; wr = code[3]; he = code[4]; tg = code[5];
      tr = code[6]; tw = code[7]; ns = code[8]; da = code[9]; db = code[10];

      claim(pr);
      cur_el = el; req_write = wr; hyp_en = he; hyp_trap_grp = tg;
      hyp_trap_rd = tr; hyp_trap_wr = tw; sec_ns = ns; sdis_a = da; sdis_b = db;
      req_wdata_lo = 32'h9E37_79B9 * (code + 1);
      req_wdata_hi = ~req_wdata_lo ^ 32'(code << 8);

      e_undef = (el == 2'd0) ||
                (el == 2'd3 && !ns && wr && (da || (!pr && db)));
      e_trap  = (el == 2'd1) && he && (tg || (wr ? tw : tr));
      e_sec   = (el == 2'd3) && !ns;
      cur     = e_sec ? m_sec : m_ns;
      img     = pr ? {req_wdata_hi, req_wdata_lo} : {32'd0, req_wdata_lo};
      e_data  = (!wr && !e_undef && !e_trap) ?
                (pr ? cur : {32'd0, cur[31:0]}) : 64'd0;
      if (wr && !e_undef && !e_trap) begin
        if (e_sec) m_sec = img; else m_ns = img;
      end

      fire();
      chk("R11 response valid", {63'd0, g_valid}, 64'd1);
      chk(el == 2'd0 ? "R2 undefined at user level" : "R8 secure write block",
          {63'd0, g_undef}, {63'd0, e_undef});
      chk(tg ? "R3 group trap" : "R4 direction trap",
          {63'd0, g_trap}, {63'd0, e_trap});
      chk("R5 syndrome", {56'd0, g_syn}, e_trap ? (pr ? 64'd4 : 64'd3) : 64'd0);
      chk(pr ? "R10 paired read data" : "R9 single read data", g_data, e_data);
      verify_banks(e_sec ? "R7 bank select" : "R6 bank select");
    end

    finish_run();
  end

endmodule